// File: doc/BRIEF.md
# Dual-bank USB OUT endpoint receive buffer

This block holds received OUT data for a single USB device endpoint in two packet banks that are filled alternately. The packet engine feeds it a byte stream framed by a start strobe, a per-byte valid strobe and an end strobe. The block answers each packet with a one-cycle ACK pulse if the packet was stored, or a NAK pulse if no bank was free when the packet began. Firmware sees one full flag per bank. It reads the stored bytes one at a time through a single data port and frees a bank by pulsing that bank's release bit.

Both banks can be full at the same time. The two flags alone do not show which packet arrived first, so the block also outputs the index of the older full bank. The byte count and the read port always present that bank. Setting a parameter restricts the block to one bank. A flush input empties everything and abandons any packet that is still arriving.

Top module: `usb_rx_pingpong`

## Requirements
- R1: After reset, `bank_full` is 00, `hs_ack` and `hs_nak` are low, `oldest_bank` is 0 and `byte_count` is 0.
- R2: A packet that reaches a free bank gets a one-cycle `hs_ack` pulse in the cycle after its `pkt_end` strobe. In that same cycle the bank's flag is set and the bank's stored length equals the number of valid bytes.
- R3: Packets fill banks in alternation. The first packet after reset or flush goes to bank 0 and the next goes to bank 1 while bank 0 is still full, so both flags can be set together.
- R4: The free/full decision is made at `pkt_start`. If no bank is free at that moment, the packet gets a one-cycle `hs_nak` pulse after `pkt_end` and stores nothing, even if a bank is released while the packet is still arriving.
- R5: `oldest_bank` names the full bank that was filled first. `byte_count` gives that bank's length, or 0 when no bank is full.
- R6: `rd_data` shows the byte at the read pointer of the presented bank. Each `rd_en` pulse advances the pointer by one, and the pointer never moves past `byte_count`. Reading does not change `byte_count`.
- R7: Bit b of `release_bank` clears the flag of bank b one cycle later, provided that bank is full. Presentation then moves to the other bank, with its pointer at byte 0. Releasing an empty bank has no effect.
- R8: A zero-length packet is accepted. It gets an ACK, sets the bank flag and gives a length of 0.
- R9: A packet of exactly `MAX_PKT` bytes is stored. A packet with more than `MAX_PKT` valid bytes gets neither ACK nor NAK and leaves its bank free.
- R10: A flush clears both flags, sets `byte_count` to 0 and `oldest_bank` to 0, and makes bank 0 the next bank to fill. A packet in progress is dropped without a handshake.
- R11: With `DUAL_BANK` = 0, only bank 0 is used, `bank_full[1]` never sets, and a packet that starts while bank 0 is full gets a NAK.
- R12: If the next bank in the alternation is full but the other bank is free, the packet goes to the free bank.
- R13: Suppose firmware releases the older bank in the same cycle as `pkt_end` of a packet going into the other bank. Then the new packet becomes the presented bank, and its length and first byte appear at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty both banks and drop any packet in progress |
| pkt_start | input | 1 | First cycle of an OUT packet |
| pkt_valid | input | 1 | `pkt_data` carries a packet byte |
| pkt_data | input | DATA_W | Received byte |
| pkt_end | input | 1 | Packet complete (a cycle with no byte) |
| hs_ack | output | 1 | One-cycle ACK answer |
| hs_nak | output | 1 | One-cycle NAK answer |
| bank_full | output | 2 | Per-bank received flags |
| oldest_bank | output | 1 | Bank that holds the older packet |
| byte_count | output | clog2(MAX_PKT+1) | Length of the presented bank |
| rd_en | input | 1 | Advance the read pointer |
| rd_data | output | DATA_W | Byte at the read pointer |
| release_bank | input | 2 | Per-bank release strobes |

## Verification
Firmware's release of the older bank can arrive in the same cycle that a packet commits into the other bank. The bench provokes this by raising `release_bank` together with `pkt_end`. It then expects the flags to show only the new bank, the older-bank output to switch to it, and the new packet's length and first byte to appear. A second collision is a release that lands while a packet, rejected at its start, is still arriving. That packet must still be answered with NAK, and the released bank must simply end up empty.

// File: rtl/usb_rxpp_pkg.sv
// Shared types for the dual-bank OUT receive buffer.
// Assumes nothing beyond a two-bank layout.
package usb_rxpp_pkg;

    typedef enum logic [1:0] {
        FILL_IDLE,
        FILL_RECV,
        FILL_REJECT,
        FILL_DROP
    } fill_state_t;

    // One-hot mask for a bank index.
    function automatic logic [1:0] bank_onehot(input logic b);
        return b ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/rxpp_fill.sv
// Bus-side fill control. Picks a target bank at packet start, steers bytes
// into it and counts them. It drops oversize packets and produces the ACK or
// NAK answer.
// Assumes pkt_end arrives in a cycle without pkt_valid and that pkt_start
// comes no earlier than the cycle after the previous pkt_end.
module rxpp_fill
    import usb_rxpp_pkg::*;
#(
    parameter int unsigned MAX_PKT   = 64,
    parameter bit          DUAL_BANK = 1'b1,
    parameter int unsigned CW        = $clog2(MAX_PKT + 1),
    parameter int unsigned AW        = $clog2(MAX_PKT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          pkt_start,
    input  logic          pkt_valid,
    input  logic          pkt_end,
    input  logic [1:0]    bank_full,
    output logic          wr_en,
    output logic          wr_bank,
    output logic [AW-1:0] wr_addr,
    output logic          commit,
    output logic          commit_bank,
    output logic [CW-1:0] commit_len,
    output logic          hs_ack,
    output logic          hs_nak
);

    localparam logic [1:0]    BANK_MASK = DUAL_BANK ? 2'b11 : 2'b01;
    localparam logic [CW-1:0] MAX_CNT   = CW'(MAX_PKT);

    fill_state_t   state;
    logic          tgt;
    logic          next_wr;
    logic [CW-1:0] cnt;
    logic [1:0]    free;
    logic          pick;
    logic          pick_ok;

    // Choose the bank for a new packet: the alternating bank first, otherwise the other one.
    always_comb begin
        free    = ~bank_full & BANK_MASK;
        pick    = next_wr;
        pick_ok = 1'b0;
        if (free[next_wr]) begin
            pick    = next_wr;
            pick_ok = 1'b1;
        end else if (free[~next_wr]) begin
            pick    = ~next_wr;
            pick_ok = 1'b1;
        end
    end

    // Byte write strobe and commit strobe for the selected bank.
    always_comb begin
        wr_en       = (state == FILL_RECV) && pkt_valid && (cnt < MAX_CNT) && !flush && !pkt_start;
        wr_bank     = tgt;
        wr_addr     = cnt[AW-1:0];
        commit      = (state == FILL_RECV) && pkt_end && !flush && !pkt_start;
        commit_bank = tgt;
        commit_len  = cnt;
    end

    // Packet state, byte counter, alternation pointer and handshake pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= FILL_IDLE;
            tgt     <= 1'b0;
            next_wr <= 1'b0;
            cnt     <= '0;
            hs_ack  <= 1'b0;
            hs_nak  <= 1'b0;
        end else begin
            hs_ack <= commit;
            hs_nak <= (state == FILL_REJECT) && pkt_end && !flush && !pkt_start;
            if (flush) begin
                state   <= FILL_IDLE;
                next_wr <= 1'b0;
                cnt     <= '0;
            end else if (pkt_start) begin
                cnt <= '0;
                if (pick_ok) begin
                    state <= FILL_RECV;
                    tgt   <= pick;
                end else begin
                    state <= FILL_REJECT;
                end
            end else begin
                case (state)
                    FILL_RECV: begin
                        if (pkt_end) begin
                            state   <= FILL_IDLE;
                            next_wr <= DUAL_BANK ? ~tgt : 1'b0;
                        end else if (pkt_valid) begin
                            if (cnt == MAX_CNT) state <= FILL_DROP;
                            else                cnt   <= cnt + CW'(1);
                        end
                    end
                    FILL_REJECT, FILL_DROP: begin
                        if (pkt_end) state <= FILL_IDLE;
                    end
                    default: state <= FILL_IDLE;
                endcase
            end
        end
    end

    // R4: a start with both banks full is rejected
    assert_reject_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start && !flush && bank_full == 2'b11) |=> (state == FILL_REJECT));

    // R2: an ACK only follows an end strobe
    assert_ack_follows_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ack |-> $past(pkt_end));

endmodule

// File: rtl/rxpp_store.sv
// Packet storage. Each bank is a byte array plus a registered length.
// Reads are combinational at the given bank and address.
// Assumes writes only target a bank whose flag is clear.
module rxpp_store #(
    parameter int unsigned MAX_PKT   = 64,
    parameter bit          DUAL_BANK = 1'b1,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CW        = $clog2(MAX_PKT + 1),
    parameter int unsigned AW        = $clog2(MAX_PKT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 wr_en,
    input  logic                 wr_bank,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 commit,
    input  logic                 commit_bank,
    input  logic [CW-1:0]        commit_len,
    input  logic                 rd_bank,
    input  logic [AW-1:0]        rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic [1:0][CW-1:0]   bank_len
);

    localparam int unsigned NB = DUAL_BANK ? 2 : 1;

    logic [1:0][DATA_W-1:0] rd_word;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        if (b < NB) begin : g_used
            logic [DATA_W-1:0] mem [MAX_PKT];
            logic [CW-1:0]     len_q;

            // Byte write into this bank.
            always_ff @(posedge clk) begin
                if (wr_en && (wr_bank == 1'(b))) mem[wr_addr] <= wr_data;
            end

            // Length capture on commit, cleared by reset or flush.
            always_ff @(posedge clk) begin
                if (!rst_n || flush)                          len_q <= '0;
                else if (commit && (commit_bank == 1'(b)))    len_q <= commit_len;
            end

            assign rd_word[b]  = mem[rd_addr];
            assign bank_len[b] = len_q;
        end else begin : g_absent
            assign rd_word[b]  = '0;
            assign bank_len[b] = '0;
        end
    end

    assign rd_data = rd_word[rd_bank];

endmodule

// File: rtl/rxpp_order.sv
// Firmware-side state: the per-bank full flags, the older-bank pointer and
// the read pointer of the presented bank.
// Assumes commit only targets a bank that is empty.
module rxpp_order
    import usb_rxpp_pkg::*;
#(
    parameter int unsigned MAX_PKT   = 64,
    parameter bit          DUAL_BANK = 1'b1,
    parameter int unsigned CW        = $clog2(MAX_PKT + 1),
    parameter int unsigned AW        = $clog2(MAX_PKT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               commit,
    input  logic               commit_bank,
    input  logic [1:0]         release_bank,
    input  logic               rd_en,
    input  logic [1:0][CW-1:0] bank_len,
    output logic [1:0]         bank_full,
    output logic               oldest,
    output logic [AW-1:0]      rd_addr,
    output logic [CW-1:0]      byte_count
);

    logic [1:0]    rel_eff;
    logic [1:0]    full_n;
    logic          older_n;
    logic [CW-1:0] cur_len;
    logic [CW-1:0] rd_ptr;

    // Next flags and next older bank after this cycle's releases and commit.
    always_comb begin
        rel_eff = release_bank & bank_full;
        full_n  = (bank_full & ~rel_eff) | (commit ? bank_onehot(commit_bank) : 2'b00);
        older_n = oldest;
        if (full_n == 2'b01)      older_n = 1'b0;
        else if (full_n == 2'b10) older_n = 1'b1;
        cur_len = bank_len[oldest];
    end

    assign byte_count = bank_full[oldest] ? cur_len : '0;
    assign rd_addr    = rd_ptr[AW-1:0];

    // Flag, older-bank and read-pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            bank_full <= 2'b00;
            oldest    <= 1'b0;
            rd_ptr    <= '0;
        end else begin
            bank_full <= full_n;
            oldest    <= older_n;
            if ((older_n != oldest) || rel_eff[oldest])
                rd_ptr <= '0;
            else if (rd_en && bank_full[oldest] && (rd_ptr < cur_len))
                rd_ptr <= rd_ptr + CW'(1);
        end
    end

    // R7: releasing a full bank empties it
    assert_release_clears_b0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (release_bank[0] && bank_full[0]) |=> !bank_full[0]);
    assert_release_clears_b1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (release_bank[1] && bank_full[1]) |=> !bank_full[1]);

    // R10: flush leaves nothing presented
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (bank_full == 2'b00 && byte_count == '0));

    // R5: the older-bank pointer names a full bank whenever one exists
    assert_oldest_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_full) |-> bank_full[oldest]);

    // R6: read pointer never runs past the presented length
    assert_ptr_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr <= byte_count);

    // R3: fill control only commits into an empty bank
    assert_commit_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !bank_full[commit_bank]);

    if (!DUAL_BANK) begin : g_single_chk
        // R11: bank 1 stays idle in single-bank mode
        assert_bank1_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !bank_full[1]);
    end

endmodule

// File: rtl/usb_rx_pingpong.sv
// Top of the dual-bank OUT endpoint receive buffer. Wires fill control,
// bank storage and firmware-side ordering together.
// Assumes framing as described in rxpp_fill and one packet at a time.
module usb_rx_pingpong #(
    parameter int unsigned MAX_PKT   = 64,
    parameter bit          DUAL_BANK = 1'b1,
    parameter int unsigned DATA_W    = 8,
    localparam int unsigned CW       = $clog2(MAX_PKT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              pkt_start,
    input  logic              pkt_valid,
    input  logic [DATA_W-1:0] pkt_data,
    input  logic              pkt_end,
    output logic              hs_ack,
    output logic              hs_nak,
    output logic [1:0]        bank_full,
    output logic              oldest_bank,
    output logic [CW-1:0]     byte_count,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [1:0]        release_bank
);

    localparam int unsigned AW = $clog2(MAX_PKT);

    logic               wr_en;
    logic               wr_bank;
    logic [AW-1:0]      wr_addr;
    logic               commit;
    logic               commit_bank;
    logic [CW-1:0]      commit_len;
    logic [AW-1:0]      rd_addr;
    logic [1:0][CW-1:0] bank_len;

    rxpp_fill #(.MAX_PKT(MAX_PKT), .DUAL_BANK(DUAL_BANK), .CW(CW), .AW(AW)) u_fill (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .pkt_start   (pkt_start),
        .pkt_valid   (pkt_valid),
        .pkt_end     (pkt_end),
        .bank_full   (bank_full),
        .wr_en       (wr_en),
        .wr_bank     (wr_bank),
        .wr_addr     (wr_addr),
        .commit      (commit),
        .commit_bank (commit_bank),
        .commit_len  (commit_len),
        .hs_ack      (hs_ack),
        .hs_nak      (hs_nak)
    );

    rxpp_store #(.MAX_PKT(MAX_PKT), .DUAL_BANK(DUAL_BANK), .DATA_W(DATA_W), .CW(CW), .AW(AW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .wr_en       (wr_en),
        .wr_bank     (wr_bank),
        .wr_addr     (wr_addr),
        .wr_data     (pkt_data),
        .commit      (commit),
        .commit_bank (commit_bank),
        .commit_len  (commit_len),
        .rd_bank     (oldest_bank),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .bank_len    (bank_len)
    );

    rxpp_order #(.MAX_PKT(MAX_PKT), .DUAL_BANK(DUAL_BANK), .CW(CW), .AW(AW)) u_order (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .commit       (commit),
        .commit_bank  (commit_bank),
        .release_bank (release_bank),
        .rd_en        (rd_en),
        .bank_len     (bank_len),
        .bank_full    (bank_full),
        .oldest       (oldest_bank),
        .rd_addr      (rd_addr),
        .byte_count   (byte_count)
    );

endmodule

// File: tb/usb_rx_pingpong_test.sv
// Testbench: a table of packet/release steps followed by directed corner tests.
module usb_rx_pingpong_test;

    localparam int CW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic pkt_start = 1'b0;
    logic pkt_valid = 1'b0;
    logic [7:0] pkt_data = 8'h00;
    logic pkt_end = 1'b0;
    logic rd_en = 1'b0;
    logic [1:0] release_bank = 2'b00;

    logic hs_ack, hs_nak, oldest_bank;
    logic [1:0] bank_full;
    logic [CW-1:0] byte_count;
    logic [7:0] rd_data;

    logic sb_ack, sb_nak, sb_old;
    logic [1:0] sb_full;
    logic [CW-1:0] sb_cnt;
    logic [7:0] sb_rd;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    usb_rx_pingpong uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pkt_start(pkt_start),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_end(pkt_end),
        .hs_ack(hs_ack), .hs_nak(hs_nak), .bank_full(bank_full),
        .oldest_bank(oldest_bank), .byte_count(byte_count), .rd_en(rd_en),
        .rd_data(rd_data), .release_bank(release_bank)
    );

    usb_rx_pingpong #(.DUAL_BANK(1'b0)) uut_single (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pkt_start(pkt_start),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_end(pkt_end),
        .hs_ack(sb_ack), .hs_nak(sb_nak), .bank_full(sb_full),
        .oldest_bank(sb_old), .byte_count(sb_cnt), .rd_en(rd_en),
        .rd_data(sb_rd), .release_bank(release_bank)
    );

    typedef struct packed {
        logic [7:0] len;     // 255 = no packet in this step
        logic [1:0] rel;     // release pulse applied before the packet
        logic       ack;
        logic       nak;
        logic [1:0] full;
        logic       old;
        logic [7:0] cnt;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'd3,   2'b00, 1'b1, 1'b0, 2'b01, 1'b0, 8'd3},   // R2 first packet into bank 0
        '{8'd5,   2'b00, 1'b1, 1'b0, 2'b11, 1'b0, 8'd3},   // R3 second into bank 1
        '{8'd2,   2'b00, 1'b0, 1'b1, 2'b11, 1'b0, 8'd3},   // R4 both full -> NAK
        '{8'd255, 2'b01, 1'b0, 1'b0, 2'b10, 1'b1, 8'd5},   // R7 release oldest
        '{8'd0,   2'b00, 1'b1, 1'b0, 2'b11, 1'b1, 8'd5},   // R8 zero-length
        '{8'd255, 2'b10, 1'b0, 1'b0, 2'b01, 1'b0, 8'd0},   // R5 presents ZLP bank
        '{8'd255, 2'b10, 1'b0, 1'b0, 2'b01, 1'b0, 8'd0},   // R7 release of empty bank ignored
        '{8'd64,  2'b00, 1'b1, 1'b0, 2'b11, 1'b0, 8'd0},   // R9 exactly max
        '{8'd255, 2'b01, 1'b0, 1'b0, 2'b10, 1'b1, 8'd64},  // R5 max packet presented
        '{8'd65,  2'b00, 1'b0, 1'b0, 2'b10, 1'b1, 8'd64},  // R9 oversize dropped
        '{8'd255, 2'b10, 1'b0, 1'b0, 2'b00, 1'b1, 8'd0},   // R7 all empty
        '{8'd1,   2'b00, 1'b1, 1'b0, 2'b01, 1'b0, 8'd1}    // R9 dropped packet left bank 0 free
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send_pkt(input int len, input logic [7:0] base, input logic [1:0] rel_end);
        @(negedge clk);
        pkt_start = 1'b1;
        @(negedge clk);
        pkt_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            pkt_valid = 1'b1;
            pkt_data  = base + 8'(i);
            @(negedge clk);
        end
        pkt_valid    = 1'b0;
        pkt_end      = 1'b1;
        release_bank = rel_end;
        @(negedge clk);
        pkt_end      = 1'b0;
        release_bank = 2'b00;
    endtask

    task automatic rel_pulse(input logic [1:0] m);
        release_bank = m;
        @(negedge clk);
        release_bank = 2'b00;
    endtask

    task automatic flush_pulse();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic read_pulse();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", "full", bank_full, 0);
        check("R1", "ack", hs_ack, 0);
        check("R1", "nak", hs_nak, 0);
        check("R1", "oldest", oldest_bank, 0);
        check("R1", "count", byte_count, 0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            if (VECS[k].rel != 2'b00) rel_pulse(VECS[k].rel);
            if (VECS[k].len != 8'd255) begin
                send_pkt(int'(VECS[k].len), 8'(k * 16), 2'b00);
                check("R2", $sformatf("vec%0d ack", k), hs_ack, VECS[k].ack);
                check("R4", $sformatf("vec%0d nak", k), hs_nak, VECS[k].nak);
            end
            check("R3", $sformatf("vec%0d full", k), bank_full, VECS[k].full);
            check("R5", $sformatf("vec%0d oldest", k), oldest_bank, VECS[k].old);
            check("R5", $sformatf("vec%0d count", k), byte_count, VECS[k].cnt);
        end

        // R6 read port walk; R13 same-cycle release and commit
        flush_pulse();
        send_pkt(4, 8'hA0, 2'b00);
        check("R6", "byte0", rd_data, 8'hA0);
        read_pulse();
        check("R6", "byte1", rd_data, 8'hA1);
        read_pulse();
        read_pulse();
        check("R6", "byte3", rd_data, 8'hA3);
        check("R6", "count unchanged", byte_count, 4);
        send_pkt(2, 8'hB0, 2'b01);
        check("R13", "ack", hs_ack, 1);
        check("R13", "full", bank_full, 2'b10);
        check("R13", "oldest", oldest_bank, 1);
        check("R13", "count", byte_count, 2);
        check("R13", "first byte", rd_data, 8'hB0);
        read_pulse();
        check("R6", "second bank byte1", rd_data, 8'hB1);

        // R4 release during a rejected packet
        send_pkt(3, 8'hC0, 2'b00);            // into bank 0, both full
        @(negedge clk);
        pkt_start = 1'b1;
        @(negedge clk);
        pkt_start = 1'b0;
        pkt_valid = 1'b1;
        pkt_data  = 8'hD0;
        release_bank = 2'b10;
        @(negedge clk);
        release_bank = 2'b00;
        pkt_valid = 1'b0;
        pkt_end = 1'b1;
        @(negedge clk);
        pkt_end = 1'b0;
        check("R4", "nak after mid release", hs_nak, 1);
        check("R4", "no ack", hs_ack, 0);
        check("R4", "full", bank_full, 2'b01);
        check("R4", "count", byte_count, 3);

        // R12 alternating bank full, other free
        flush_pulse();
        send_pkt(3, 8'h10, 2'b00);
        send_pkt(2, 8'h20, 2'b00);
        rel_pulse(2'b10);
        send_pkt(4, 8'h30, 2'b00);
        check("R12", "ack", hs_ack, 1);
        check("R12", "full", bank_full, 2'b11);
        rel_pulse(2'b01);
        check("R12", "oldest", oldest_bank, 1);
        check("R12", "count", byte_count, 4);
        check("R12", "data", rd_data, 8'h30);

        // R10 flush with data, then flush mid-packet
        send_pkt(1, 8'h40, 2'b00);
        flush_pulse();
        check("R10", "full", bank_full, 0);
        check("R10", "count", byte_count, 0);
        check("R10", "oldest", oldest_bank, 0);
        @(negedge clk);
        pkt_start = 1'b1;
        @(negedge clk);
        pkt_start = 1'b0;
        pkt_valid = 1'b1;
        pkt_data  = 8'h50;
        @(negedge clk);
        pkt_valid = 1'b0;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        pkt_end = 1'b1;
        @(negedge clk);
        pkt_end = 1'b0;
        check("R10", "no ack", hs_ack, 0);
        check("R10", "no nak", hs_nak, 0);
        check("R10", "nothing stored", bank_full, 0);
        send_pkt(2, 8'h60, 2'b00);
        check("R10", "refill bank0", bank_full, 2'b01);
        check("R10", "data", rd_data, 8'h60);

        // R11 single-bank instance
        flush_pulse();
        send_pkt(3, 8'h70, 2'b00);
        check("R11", "ack", sb_ack, 1);
        check("R11", "full", sb_full, 2'b01);
        send_pkt(2, 8'h80, 2'b00);
        check("R11", "nak", sb_nak, 1);
        check("R11", "no ack", sb_ack, 0);
        check("R11", "full stays", sb_full, 2'b01);
        check("R11", "count", sb_cnt, 3);
        check("R11", "oldest", sb_old, 0);
        rel_pulse(2'b11);
        check("R11", "released", sb_full, 2'b00);
        send_pkt(1, 8'h90, 2'b00);
        check("R11", "bank0 again", sb_full, 2'b01);
        check("R11", "data", sb_rd, 8'h90);

        finish_run();
    end

endmodule